// File: doc/BRIEF.md
# One-Entry Streaming Queue

This block keeps a single item in one register, with a valid/ready style handshake on both sides. A producer offers an item with `push_en` and sees `push_ready`. A consumer sees `pop_ready` and the item on `head_data`, and takes it with `pop_en`. A `flush` input empties the slot.

The slot accepts a new item while it still holds one, as long as the consumer removes the held item in the same cycle. To allow this, `pop_en` feeds `push_ready` through combinational logic. A producer and a consumer can therefore stream one item per clock through a single register, with no idle cycle between items. `head_data` always comes from the register, so in a cycle where an item is swapped it still shows the old item.

The reset input is asserted asynchronously and released through a short synchronizer. The slot therefore comes out of reset a fixed number of clock edges after `rst_n` rises.

Top module: `spq_pipe1`

## Requirements
- R1: While reset is held, and once it has been released (two rising clock edges after `rst_n` goes high with the default synchronizer), the slot is empty: `pop_ready` is 0 and `push_ready` is 1.
- R2: When the slot is empty and `push_en` is 1, the item is accepted. After that clock edge `pop_ready` is 1 and `head_data` equals the pushed value.
- R3: When the slot is full and `pop_en` is 0, `push_ready` is 0. A `push_en` in that cycle is ignored: after the edge `head_data` still shows the old item and `pop_ready` stays 1.
- R4: When the slot is full and `pop_en` is 1, `push_ready` is 1 in that same cycle.
- R5: When a pop and a push both fire in one cycle, `head_data` shows the old item during that cycle. After the edge the slot is full and holds the new item.
- R6: A pop with no push empties the slot: after the edge `pop_ready` is 0.
- R7: `pop_en` while the slot is empty has no effect: `pop_ready` stays 0 and `push_ready` stays 1.
- R8: `flush` takes priority over push and pop in the same cycle: after the edge the slot is empty, whatever else fired.
- R9: With `push_en` and `pop_en` held high, items pass through at one per cycle. Every accepted item leaves exactly once, in order, and `push_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_en | input | 1 | Producer offers `push_data` this cycle |
| push_data | input | WIDTH | Item offered by the producer |
| push_ready | output | 1 | Slot can take an item this cycle (empty, or popping now) |
| pop_en | input | 1 | Consumer takes the held item this cycle |
| pop_ready | output | 1 | Slot holds an item |
| head_data | output | WIDTH | Held item, valid while `pop_ready` is 1 |
| flush | input | 1 | Empty the slot at the next edge, overriding push and pop |

## Verification
The bench builds the block with WIDTH = 12 and SYNC_STAGES = 2. The 12-bit width lets test items use values above 8 bits, so a truncated data path shows up as a scoreboard mismatch. The two-stage synchronizer puts a fixed, short gap between the release of `rst_n` and the first accepted item, which the reset checks rely on. A long streaming run with both handshakes held high, plus flushes that land on a push or on a swap, exercises the same-cycle pop-then-push path against a scoreboard queue.

// File: rtl/spq_pkg.sv
package spq_pkg;

  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_HELD  = 1'b1
  } slot_e;

  // Next occupancy: flush wins, then an accepted push, then a pop.
  function automatic slot_e slot_next(input slot_e cur, input logic push_fire,
                                      input logic pop_fire, input logic flush);
    slot_e nxt;
    nxt = cur;
    if (flush)          nxt = SLOT_EMPTY;
    else if (push_fire) nxt = SLOT_HELD;
    else if (pop_fire)  nxt = SLOT_EMPTY;
    return nxt;
  endfunction

endpackage

// File: rtl/spq_rst_sync.sv
module spq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LastIdx = STAGES - 1;

  logic [LastIdx:0] chain_d, chain_q;

  always_comb begin
    chain_d = {chain_q[LastIdx-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LastIdx];
endmodule

// File: rtl/spq_occ_ctrl.sv
module spq_occ_ctrl
  import spq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push_en,
  input  logic pop_en,
  input  logic flush,
  output logic push_ready,
  output logic pop_ready,
  output logic push_fire
);
  slot_e slot_d, slot_q;
  logic  pop_fire;

  always_comb begin
    pop_ready  = (slot_q == SLOT_HELD);
    pop_fire   = pop_en && pop_ready;
    // Pop is ordered ahead of push: a pop this cycle frees the slot.
    push_ready = (slot_q == SLOT_EMPTY) || pop_fire;
    push_fire  = push_en && push_ready;
    slot_d     = slot_next(slot_q, push_fire, pop_fire, flush);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= SLOT_EMPTY;
    else        slot_q <= slot_d;
  end

  // R7
  empty_pop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_ready && !push_en) |=> !pop_ready);
endmodule

// File: rtl/spq_data_reg.sv
module spq_data_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d, q_q;

  always_comb begin
    q_d = load ? d : q_q;
  end

  always_ff @(posedge clk) begin
    q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/spq_pipe1.sv
module spq_pipe1 #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [WIDTH-1:0] push_data,
  output logic             push_ready,
  input  logic             pop_en,
  output logic             pop_ready,
  output logic [WIDTH-1:0] head_data,
  input  logic             flush
);
  logic rst_s_n;
  logic push_fire;

  spq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  spq_occ_ctrl u_occ (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .push_en    (push_en),
    .pop_en     (pop_en),
    .flush      (flush),
    .push_ready (push_ready),
    .pop_ready  (pop_ready),
    .push_fire  (push_fire)
  );

  spq_data_reg #(.WIDTH(WIDTH)) u_data (
    .clk  (clk),
    .load (push_fire),
    .d    (push_data),
    .q    (head_data)
  );

  // R2
  fill_empty_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!pop_ready && push_en && !flush) |=> (pop_ready && head_data == $past(push_data)));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pop_ready && !pop_en && !flush) |=> (pop_ready && $stable(head_data)));

  // R5
  swap_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pop_ready && pop_en && push_en && !flush) |=> (pop_ready && head_data == $past(push_data)));

  // R6
  drain_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pop_ready && pop_en && !push_en && !flush) |=> !pop_ready);

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    flush |=> !pop_ready);
endmodule

// File: tb/spq_pipe1_bench.sv
`timescale 1ns/1ps
module spq_pipe1_bench;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         push_en, pop_en, flush;
  logic [W-1:0] push_data;
  logic         push_ready, pop_ready;
  logic [W-1:0] head_data;

  int checks = 0;
  int errors = 0;
  int push_cnt = 0;
  int pop_cnt = 0;
  bit finished = 1'b0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  spq_pipe1 #(.WIDTH(W), .SYNC_STAGES(2)) u_spq_pipe1 (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_data(push_data),
    .push_ready(push_ready), .pop_en(pop_en), .pop_ready(pop_ready),
    .head_data(head_data), .flush(flush)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: apply inputs at the falling edge, record accepted items.
  task automatic drive(input bit pe, input int d, input bit oe, input bit fl);
    @(negedge clk);
    push_en   = pe;
    push_data = W'(d);
    pop_en    = oe;
    flush     = fl;
    #1;
    if (rst_n && push_en && push_ready) begin
      exp_q.push_back(int'(push_data));
      push_cnt++;
    end
  endtask

  // Monitor: just before the rising edge, compare every item that leaves.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && pop_en && pop_ready) begin
        pop_cnt++;
        if (exp_q.size() == 0) check(1'b0, "R9 pop with empty scoreboard", int'(head_data), 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(int'(head_data) == e, "R9 scoreboard order", int'(head_data), e);
        end
      end
      if (flush) exp_q.delete();
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; push_en = 1'b0; pop_en = 1'b0; flush = 1'b0; push_data = '0;
    repeat (3) @(negedge clk);
    #1;
    check(pop_ready == 1'b0, "R1 pop_ready in reset", int'(pop_ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    drive(0, 0, 0, 0);
    check(pop_ready == 1'b0, "R1 empty after release", int'(pop_ready), 0);
    check(push_ready == 1'b1, "R1 push_ready after release", int'(push_ready), 1);

    // R7: pop while empty
    drive(0, 0, 1, 0);
    drive(0, 0, 0, 0);
    check(pop_ready == 1'b0, "R7 still empty", int'(pop_ready), 0);
    check(push_ready == 1'b1, "R7 push_ready kept", int'(push_ready), 1);

    // R2: push into empty
    drive(1, 'h0A5, 0, 0);
    drive(0, 0, 0, 0);
    check(pop_ready == 1'b1, "R2 full after push", int'(pop_ready), 1);
    check(int'(head_data) == 'h0A5, "R2 head value", int'(head_data), 'h0A5);

    // R3: push while full, no pop
    drive(1, 'h03C, 0, 0);
    check(push_ready == 1'b0, "R3 push_ready low when full", int'(push_ready), 0);
    drive(0, 0, 0, 0);
    check(int'(head_data) == 'h0A5, "R3 head unchanged", int'(head_data), 'h0A5);
    check(pop_ready == 1'b1, "R3 still full", int'(pop_ready), 1);

    // R4 / R5: swap
    drive(1, 'h911, 1, 0);
    check(push_ready == 1'b1, "R4 push_ready with pop", int'(push_ready), 1);
    check(int'(head_data) == 'h0A5, "R5 old head during swap", int'(head_data), 'h0A5);
    drive(0, 0, 0, 0);
    check(pop_ready == 1'b1, "R5 full after swap", int'(pop_ready), 1);
    check(int'(head_data) == 'h911, "R5 new head after swap", int'(head_data), 'h911);

    // R6: pop alone
    drive(0, 0, 1, 0);
    drive(0, 0, 0, 0);
    check(pop_ready == 1'b0, "R6 empty after pop", int'(pop_ready), 0);

    // R8: flush with push into empty
    drive(1, 'h222, 0, 1);
    drive(0, 0, 0, 0);
    check(pop_ready == 1'b0, "R8 flush beats push", int'(pop_ready), 0);
    // R8: flush with swap
    drive(1, 'h333, 0, 0);
    drive(1, 'h444, 1, 1);
    drive(0, 0, 0, 0);
    check(pop_ready == 1'b0, "R8 flush beats swap", int'(pop_ready), 0);
    check(push_ready == 1'b1, "R8 push_ready after flush", int'(push_ready), 1);

    // R9: streaming one item per cycle
    push_cnt = 0; pop_cnt = 0;
    begin
      int low_ready;
      low_ready = 0;
      for (int i = 0; i < 40; i++) begin
        drive(1, 'hB00 + i, 1, 0);
        if (!push_ready) low_ready++;
      end
      check(low_ready == 0, "R9 push_ready held high", low_ready, 0);
    end
    drive(0, 0, 1, 0);
    drive(0, 0, 0, 0);
    check(push_cnt == 40, "R9 items accepted", push_cnt, 40);
    check(pop_cnt == 40, "R9 items delivered", pop_cnt, 40);
    check(exp_q.size() == 0, "R9 nothing left", exp_q.size(), 0);
    check(pop_ready == 1'b0, "R9 empty after drain", int'(pop_ready), 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule